// File: doc/BRIEF.md
# Fixed-Vector Interrupt Acknowledge Unit

This unit serves three active-low maskable interrupt request lines. Each line has its own vector that never changes. Each line is synchronised, and the unit samples the lines only when the two interrupt-enable flags allow it and the core signals an instruction boundary. When several lines are active, the highest-priority one wins. On acceptance the unit clears both enable flags and runs an acknowledge transaction that raises only the dedicated acknowledge strobe.

After the acknowledge, the unit asks the core to push the interrupted program counter and waits for the core to confirm the push. It then presents the 32-bit address of the vector table entry with a one-cycle valid pulse. That address is built from three parts: a 16-bit extend value in the top bits, a 7-bit base field in the middle bits, and the per-source vector in the low nine bits. The core fetches the handler start from this address. Software enable and disable inputs set or clear both flags together.

Top module: `vec_ack_unit`

## Requirements
- R1: While rst_ni is low and after it rises, ief1_o, ief2_o, ack_o, push_req_o and vec_valid_o are all 0.
- R2: A high ei_i sets ief1_o and ief2_o one cycle later. A high di_i clears both one cycle later. When both inputs are high, di_i wins.
- R3: A request is accepted only when ief1_o is 1 and boundary_i is high. Each line passes two synchroniser flops, so a line driven low before clock edge k brings ack_o high after edge k+2 at the earliest.
- R4: When several lines are low at once, line 1 (irq_ni[0]) wins over line 2 (irq_ni[1]), and line 2 wins over line 3 (irq_ni[2]).
- R5: On the edge where a request is accepted, ief1_o and ief2_o both go to 0 as ack_o rises.
- R6: ack_o stays high for exactly two cycles, and push_req_o is 0 during those cycles.
- R7: push_req_o rises on the edge where ack_o falls. It holds until push_done_i is sampled high, and vec_valid_o stays 0 for as long as push_req_o is high.
- R8: While vec_valid_o is high, vec_addr_o equals {ext, base, vector}. Here ext is ext_i and base is base_i, both taken on the acceptance edge. The 9-bit vector is 0x000 for line 1, 0x004 for line 2 and 0x008 for line 3.
- R9: vec_valid_o is a one-cycle pulse, one cycle after push_done_i is sampled. The unit then returns to idle and does not accept again until the flags are re-enabled.
- R10: Requests that arrive while ief1_o is 0 produce no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_ni | input | 3 | Active-low request lines; bit 0 is line 1 |
| ext_i | input | 16 | Extend value for address bits 31:16 |
| base_i | input | 7 | Base field for address bits 15:9 |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ei_i | input | 1 | Set both enable flags |
| di_i | input | 1 | Clear both enable flags |
| push_done_i | input | 1 | Core has finished pushing the return PC |
| ief1_o | output | 1 | Enable flag 1 |
| ief2_o | output | 1 | Enable flag 2 |
| ack_o | output | 1 | Acknowledge strobe, active high |
| push_req_o | output | 1 | Request to push the return PC |
| vec_addr_o | output | 32 | Vector table entry address |
| vec_valid_o | output | 1 | One-cycle pulse qualifying vec_addr_o |

## Verification
The bench drives all seven non-empty combinations of active request lines. This separates single-source vectors from priority resolution among two and three sources. Each combination runs with three different extend and base patterns, and those inputs are scrambled right after acceptance, which shows the address is captured rather than passed through. Push-completion delays from zero to two cycles separate the handshake wait from a fixed-latency path. Directed cases with the enable flags cleared, the boundary strobe low, and simultaneous enable and disable cover the gating rules.

// File: rtl/vec_ack_pkg.sv
package vec_ack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_PUSH = 2'd2,
    ST_ADDR = 2'd3
  } ack_state_e;
endpackage

// File: rtl/vec_ack_sync.sv
module vec_ack_sync #(
  parameter int N_LINES = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] async_i,
  output logic [N_LINES-1:0] sync_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/vec_ack_prio.sv
module vec_ack_prio #(
  parameter int N_LINES = 3,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] req_i,
  output logic [N_LINES-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  // lowest index wins: scan downward so the last hit is the winner
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/vec_ack_addr.sv
module vec_ack_addr #(
  parameter int N_LINES  = 3,
  parameter int EXT_W    = 16,
  parameter int BASE_W   = 7,
  parameter int VEC_W    = 9,
  parameter int VEC_STEP = 4,
  localparam int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int ADDR_W  = EXT_W + BASE_W + VEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [VEC_W-1:0]  vec_sel;
  logic [ADDR_W-1:0] addr_q;

  always_comb vec_sel = VEC_W'(idx_i) * VEC_W'(VEC_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= {ext_i, base_i, vec_sel};
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vec_ack_unit.sv
module vec_ack_unit #(
  parameter int N_LINES     = 3,
  parameter int EXT_W       = 16,
  parameter int BASE_W      = 7,
  parameter int VEC_W       = 9,
  parameter int VEC_STEP    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ACK_CYCLES  = 2,
  localparam int IDX_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int ADDR_W     = EXT_W + BASE_W + VEC_W,
  localparam int CNT_W      = $clog2(ACK_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LINES-1:0] irq_ni,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              boundary_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              push_done_i,
  output logic              ief1_o,
  output logic              ief2_o,
  output logic              ack_o,
  output logic              push_req_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              vec_valid_o
);
  import vec_ack_pkg::*;

  logic [N_LINES-1:0] req_sync;
  logic [N_LINES-1:0] grant;
  logic [IDX_W-1:0]   win_idx;
  logic               any_req;
  logic               accept;
  logic               ief1_q, ief2_q;
  logic [CNT_W-1:0]   ack_cnt_q;
  ack_state_e         state_q;

  vec_ack_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(~irq_ni),
    .sync_o (req_sync)
  );

  vec_ack_prio #(.N_LINES(N_LINES)) u_prio (
    .req_i  (req_sync),
    .grant_o(grant),
    .idx_o  (win_idx),
    .any_o  (any_req)
  );

  assign accept = (state_q == ST_IDLE) && ief1_q && boundary_i && any_req;

  vec_ack_addr #(
    .N_LINES(N_LINES), .EXT_W(EXT_W), .BASE_W(BASE_W),
    .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)
  ) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .idx_i (win_idx),
    .ext_i (ext_i),
    .base_i(base_i),
    .addr_o(vec_addr_o)
  );

  // acceptance clear beats disable, disable beats enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ief1_q <= 1'b0;
      ief2_q <= 1'b0;
    end else if (accept || di_i) begin
      ief1_q <= 1'b0;
      ief2_q <= 1'b0;
    end else if (ei_i) begin
      ief1_q <= 1'b1;
      ief2_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ack_cnt_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_ACK;
          ack_cnt_q <= '0;
        end
        ST_ACK: begin
          if (ack_cnt_q == CNT_W'(ACK_CYCLES - 1)) state_q <= ST_PUSH;
          else ack_cnt_q <= ack_cnt_q + 1'b1;
        end
        ST_PUSH: if (push_done_i) state_q <= ST_ADDR;
        ST_ADDR: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ief1_o      = ief1_q;
  assign ief2_o      = ief2_q;
  assign ack_o       = (state_q == ST_ACK);
  assign push_req_o  = (state_q == ST_PUSH);
  assign vec_valid_o = (state_q == ST_ADDR);

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (any_req == (grant != '0))); // R4
  AST_ACCEPT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(ief1_o && boundary_i && (req_sync != '0))); // R3
  AST_IEF_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> !ief1_o && !ief2_o); // R5
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |=> ack_o); // R6
  AST_ACK_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !push_req_o && !vec_valid_o); // R6
  AST_PUSH_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> push_req_o); // R7
  AST_PUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o && !push_done_i |=> push_req_o && !vec_valid_o); // R7
  AST_VALID_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> $past(push_req_o && push_done_i)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o && !ack_o); // R9
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (int'(vec_addr_o[VEC_W-1:0]) < N_LINES * VEC_STEP) &&
                    (int'(vec_addr_o[VEC_W-1:0]) % VEC_STEP == 0)); // R8
endmodule

// File: tb/vec_ack_unit_tb.sv
module vec_ack_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  irq_ni = 3'b111;
  logic [15:0] ext_i = '0;
  logic [6:0]  base_i = '0;
  logic        boundary_i = 1'b0;
  logic        ei_i = 1'b0;
  logic        di_i = 1'b0;
  logic        push_done_i = 1'b0;
  logic        ief1_o, ief2_o, ack_o, push_req_o, vec_valid_o;
  logic [31:0] vec_addr_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  vec_ack_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_ni(irq_ni), .ext_i(ext_i),
    .base_i(base_i), .boundary_i(boundary_i), .ei_i(ei_i), .di_i(di_i),
    .push_done_i(push_done_i), .ief1_o(ief1_o), .ief2_o(ief2_o),
    .ack_o(ack_o), .push_req_o(push_req_o), .vec_addr_o(vec_addr_o),
    .vec_valid_o(vec_valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic enable_flags();
    @(negedge clk_i); ei_i = 1'b1;
    @(negedge clk_i); ei_i = 1'b0;
    chk(ief1_o && ief2_o, "R2 enable", {ief1_o, ief2_o}, 2'b11);
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // drive a request pattern and walk the whole acknowledge sequence
  task automatic service(input logic [2:0] mask, input logic [15:0] ext,
                         input logic [6:0] base, input int dly);
    int idx;
    logic [31:0] exp;
    idx = mask[0] ? 0 : (mask[1] ? 1 : 2);
    exp = {ext, base, 9'(idx * 4)};
    @(negedge clk_i);
    irq_ni = ~mask; ext_i = ext; base_i = base; boundary_i = 1'b1;
    for (int n = 1; n <= 2; n++) begin
      @(negedge clk_i);
      chk(!ack_o, "R3 sync latency", ack_o, 0);
    end
    @(negedge clk_i);
    chk(ack_o, "R3 ack start", ack_o, 1);
    chk(!ief1_o && !ief2_o, "R5 flags cleared", {ief1_o, ief2_o}, 0);
    ext_i = ~ext; base_i = ~base;
    @(negedge clk_i);
    chk(ack_o && !push_req_o, "R6 ack second cycle", {ack_o, push_req_o}, 2'b10);
    @(negedge clk_i);
    chk(!ack_o && push_req_o, "R6 ack ends / R7 push", {ack_o, push_req_o}, 2'b01);
    for (int d = 0; d < dly; d++) begin
      @(negedge clk_i);
      chk(push_req_o && !vec_valid_o, "R7 push held", {push_req_o, vec_valid_o}, 2'b10);
    end
    push_done_i = 1'b1;
    @(negedge clk_i);
    push_done_i = 1'b0;
    chk(vec_valid_o && !push_req_o, "R9 valid pulse", {vec_valid_o, push_req_o}, 2'b10);
    chk(vec_addr_o == exp, "R8 R4 address", vec_addr_o, exp);
    @(negedge clk_i);
    chk(!vec_valid_o && !push_req_o, "R9 back to idle", {vec_valid_o, push_req_o}, 0);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk_i);
      chk(!ack_o, "R9 R10 no re-accept", ack_o, 0);
    end
    irq_ni = 3'b111;
    idle_gap(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle_gap(2);
    chk({ief1_o, ief2_o, ack_o, push_req_o, vec_valid_o} == 0, "R1 in reset",
        {ief1_o, ief2_o, ack_o, push_req_o, vec_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({ief1_o, ief2_o, ack_o, push_req_o, vec_valid_o} == 0, "R1 after reset",
        {ief1_o, ief2_o, ack_o, push_req_o, vec_valid_o}, 0);

    // R10: flags cleared, requests present
    irq_ni = 3'b000; boundary_i = 1'b1;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk_i);
      chk(!ack_o, "R10 masked", ack_o, 0);
    end
    irq_ni = 3'b111;
    idle_gap(3);

    // R2: enable, then enable+disable together
    enable_flags();
    @(negedge clk_i); ei_i = 1'b1; di_i = 1'b1;
    @(negedge clk_i); ei_i = 1'b0; di_i = 1'b0;
    chk(!ief1_o && !ief2_o, "R2 disable wins", {ief1_o, ief2_o}, 0);
    enable_flags();
    @(negedge clk_i); di_i = 1'b1;
    @(negedge clk_i); di_i = 1'b0;
    chk(!ief1_o && !ief2_o, "R2 disable", {ief1_o, ief2_o}, 0);

    // R3: boundary strobe gates acceptance
    enable_flags();
    boundary_i = 1'b0; irq_ni = 3'b011; ext_i = 16'h1234; base_i = 7'h2a;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk_i);
      chk(!ack_o, "R3 boundary low", ack_o, 0);
    end
    boundary_i = 1'b1;
    @(negedge clk_i);
    chk(ack_o, "R3 boundary high", ack_o, 1);
    idle_gap(2);
    push_done_i = 1'b1;
    @(negedge clk_i); push_done_i = 1'b0;
    chk(vec_valid_o && vec_addr_o == {16'h1234, 7'h2a, 9'h008}, "R8 line3 address",
        vec_addr_o, {16'h1234, 7'h2a, 9'h008});
    irq_ni = 3'b111;
    idle_gap(4);

    // sweep all request patterns, address patterns and push delays
    for (int m = 1; m < 8; m++) begin
      for (int p = 0; p < 3; p++) begin
        logic [15:0] e;
        logic [6:0]  b;
        e = (p == 0) ? 16'hffff : (p == 1) ? 16'h0000 : 16'(16'ha5c3 + m * 16'h0101);
        b = (p == 0) ? 7'h00 : (p == 1) ? 7'h7f : 7'(7'h15 + m);
        enable_flags();
        service(3'(m), e, b, p);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule